// File: doc/BRIEF.md
# Dual-Edge Differential Manchester Line Encoder

This block turns a serial stream of data bits into a differential Manchester line signal. It runs from one clock whose frequency equals the bit rate. It still places transitions at half-bit positions, because it uses two storage elements. One element updates on the rising clock edge and the other on the falling edge. The line level is the exclusive-or of the two. To set the line to a chosen level on an edge, the element clocked on that edge loads the chosen level XORed with the current value of the element on the other edge.

A bit period begins on a rising edge, and the encoder samples the data bit and the enable there. While enabled, the line inverts at every bit boundary. It inverts once more at mid-bit, on the falling edge, when the bit is a zero. A one leaves the line steady at mid-bit. With enable low, the line holds its level. An active-high asynchronous reset brings the line low.

Top module: `dme_top`

## Requirements
- R1: While `rst` is high, `line_out` is 0. This takes effect at once, without waiting for a clock edge, and holds for as long as `rst` stays high, whatever the other inputs do.
- R2: When `tx_en` is 1 at a rising edge of `clk`, `line_out` inverts just after that edge. That edge opens one bit period.
- R3: When the bit sampled at the opening rising edge is 0 (`tx_bit` = 0 with `tx_en` = 1), `line_out` inverts again just after the next falling edge.
- R4: When the sampled bit is 1, `line_out` keeps its level across the falling edge of that period.
- R5: The mid-bit action depends only on the values captured at the opening rising edge. A change on `tx_bit` after that edge does not affect the falling-edge transition.
- R6: When `tx_en` is 0 at a rising edge, `line_out` does not change at that edge or at the following falling edge.
- R7: One bit is sent per clock period with no gaps. Over any stream, the number of line transitions equals one per enabled 1-bit plus two per enabled 0-bit.
- R8: Raising `tx_en` after a rising edge, within a period that was opened with `tx_en` = 0, produces no falling-edge transition in that period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit-rate clock; a rising edge opens each bit period |
| rst | input | 1 | Asynchronous reset, active high |
| tx_en | input | 1 | Send enable, sampled on the rising edge |
| tx_bit | input | 1 | Data bit, sampled on the rising edge |
| line_out | output | 1 | Encoded line level |

## Verification
A 0 bit puts a boundary transition and a mid-bit transition inside the same clock period. The two come from different storage elements, and each must read the other's current value. The bench sends runs of zeros back to back, mixed with ones and idle periods, so that both edges act in every period. It samples `line_out` 5 ns after each rising edge and 5 ns after each falling edge, and compares both samples against levels queued by the driver. The bench also changes `tx_bit` and `tx_en` between the rising edge and the falling edge. It then judges that the falling-edge action still follows the values captured at the rising edge.

// File: rtl/dme_pkg.sv
`timescale 1ns/1ps
package dme_pkg;

    // Level the line takes out of reset.
    localparam logic LINE_IDLE = 1'b0;

    // What the rising edge captured for the current bit period.
    typedef struct packed {
        logic active;   // period was opened with enable high
        logic bit_val;  // data bit of the period
    } dme_slot_t;

    localparam dme_slot_t SLOT_IDLE = '{active: 1'b0, bit_val: 1'b0};

    // Value an edge register must load so that the XOR line equals target.
    function automatic logic load_for_level(input logic target, input logic opposite);
        return target ^ opposite;
    endfunction

    // A mid-bit inversion is owed only by an enabled zero bit.
    function automatic logic wants_mid_flip(input dme_slot_t s);
        return s.active & ~s.bit_val;
    endfunction

endpackage

// File: rtl/dme_slot_reg.sv
`timescale 1ns/1ps
module dme_slot_reg
    import dme_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  dme_slot_t slot_d,
    output dme_slot_t slot_q
);

    // Captured on the opening rising edge; the falling edge reads only this copy.
    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            slot_q <= SLOT_IDLE;
        end else begin
            slot_q <= slot_d;
        end
    end

endmodule

// File: rtl/dme_edge_reg.sv
`timescale 1ns/1ps
module dme_edge_reg
    import dme_pkg::*;
#(
    parameter bit FALLING = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic d,
    output logic q
);

    generate
        if (FALLING) begin : g_fall
            always_ff @(negedge clk or posedge rst) begin
                if (rst) begin
                    q <= LINE_IDLE;
                end else if (load) begin
                    q <= d;
                end
            end
        end else begin : g_rise
            always_ff @(posedge clk or posedge rst) begin
                if (rst) begin
                    q <= LINE_IDLE;
                end else if (load) begin
                    q <= d;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/dme_top.sv
`timescale 1ns/1ps
module dme_top
    import dme_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic tx_en,
    input  logic tx_bit,
    output logic line_out
);

    logic      rise_q;
    logic      fall_q;
    logic      rise_d;
    logic      fall_d;
    logic      fall_load;
    dme_slot_t slot_d;
    dme_slot_t slot_q;

    assign line_out = rise_q ^ fall_q;

    always_comb begin
        slot_d.active  = tx_en;
        slot_d.bit_val = tx_bit;
    end

    // Each edge aims for the inverse of the present line level.
    assign rise_d    = load_for_level(~line_out, fall_q);
    assign fall_d    = load_for_level(~line_out, rise_q);
    assign fall_load = wants_mid_flip(slot_q);

    dme_slot_reg u_slot (
        .clk    (clk),
        .rst    (rst),
        .slot_d (slot_d),
        .slot_q (slot_q)
    );

    dme_edge_reg #(.FALLING(1'b0)) u_rise (
        .clk  (clk),
        .rst  (rst),
        .load (tx_en),
        .d    (rise_d),
        .q    (rise_q)
    );

    dme_edge_reg #(.FALLING(1'b1)) u_fall (
        .clk  (clk),
        .rst  (rst),
        .load (fall_load),
        .d    (fall_d),
        .q    (fall_q)
    );

endmodule

// File: rtl/dme_checks.sv
`timescale 1ns/1ps
module dme_checks (
    input logic clk,
    input logic rst,
    input logic tx_en,
    input logic tx_bit,
    input logic line_out
);

    // Line level seen at consecutive rising edges spans one full bit period.
    p_reset_low_r1: assert property (@(posedge clk) rst |-> !line_out);

    p_one_bit_single_flip_r4: assert property (@(posedge clk) disable iff (rst)
        (tx_en && tx_bit) |=> (line_out != $past(line_out)));

    p_zero_bit_double_flip_r3: assert property (@(posedge clk) disable iff (rst)
        (tx_en && !tx_bit) |=> (line_out == $past(line_out)));

    p_idle_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !tx_en |=> $stable(line_out));

endmodule

bind dme_top dme_checks u_dme_checks (
    .clk      (clk),
    .rst      (rst),
    .tx_en    (tx_en),
    .tx_bit   (tx_bit),
    .line_out (line_out)
);

// File: tb/test_dme_top.sv
`timescale 1ns/1ps
module test_dme_top;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tx_en = 1'b0;
    logic tx_bit = 1'b0;
    logic line_out;

    always #10 clk = ~clk;

    dme_top i_dme_top (
        .clk      (clk),
        .rst      (rst),
        .tx_en    (tx_en),
        .tx_bit   (tx_bit),
        .line_out (line_out)
    );

    typedef struct {
        logic  after_rise;
        logic  after_fall;
        string tag;
    } exp_t;

    exp_t sb[$];
    exp_t mon_e;
    logic model_line = 1'b0;
    int   n_cmp = 0;
    int   n_bad = 0;
    int   flips = 0;
    int   flips_base = 0;
    int   flips_exp = 0;
    bit   finished = 0;

    always @(line_out) flips++;

    task automatic check(input logic act, input logic exp, input string tag);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: line_out=%b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_int(input int act, input int exp, input string tag);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    // Driver: sets inputs before a rising edge, queues the expected levels,
    // then applies the mid-period values after that edge.
    task automatic send(input logic en, input logic b, input logic mid_en,
                        input logic mid_b, input string tag);
        exp_t e;
        @(negedge clk);
        #2;
        tx_en  = en;
        tx_bit = b;
        if (en) model_line = ~model_line;
        e.after_rise = model_line;
        if (en && !b) model_line = ~model_line;
        e.after_fall = model_line;
        e.tag = tag;
        sb.push_back(e);
        @(posedge clk);
        #3;
        tx_en  = mid_en;
        tx_bit = mid_b;
    endtask

    task automatic drain();
        wait (sb.size() == 0);
        @(negedge clk);
        #8;
    endtask

    // Monitor: pops one item per opened period, compares after both edges.
    initial begin
        forever begin
            @(posedge clk);
            if (sb.size() > 0) begin
                mon_e = sb.pop_front();
                #5;
                check(line_out, mon_e.after_rise, {"R2 boundary ", mon_e.tag});
                @(negedge clk);
                #5;
                check(line_out, mon_e.after_fall, {"mid-bit ", mon_e.tag});
            end
        end
    end

    initial begin
        #5;
        check(line_out, 1'b0, "R1 reset at start");
        repeat (2) @(posedge clk);
        #5;
        check(line_out, 1'b0, "R1 reset held over edges");
        @(negedge clk);
        #2;
        rst = 1'b0;

        repeat (3) send(1, 1, 1, 1, "R4 ones");
        repeat (3) send(1, 0, 1, 0, "R3 zeros");
        for (int i = 0; i < 6; i++) send(1, i[0], 1, i[0], "R3/R4 alternating");
        send(0, 1, 0, 1, "R6 idle one");
        send(0, 0, 0, 0, "R6 idle zero");
        send(1, 0, 1, 1, "R5 zero then input rises");
        send(1, 1, 1, 0, "R5 one then input falls");
        send(0, 0, 1, 0, "R8 enable raised mid-period");
        send(0, 0, 0, 0, "R6 idle after R8");
        drain();

        flips_base = flips;
        flips_exp  = 0;
        for (int i = 0; i < 300; i++) begin
            logic en_r;
            logic b_r;
            logic mb_r;
            en_r = ($urandom % 4) != 0;
            b_r  = 1'($urandom % 2);
            mb_r = 1'($urandom % 2);
            if (en_r) flips_exp += b_r ? 1 : 2;
            send(en_r, b_r, en_r, mb_r, "R7 random stream");
        end
        send(0, 0, 0, 0, "R6 idle tail");
        drain();
        check_int(flips - flips_base, flips_exp, "R7 transition count");

        if (model_line == 1'b0) send(1, 1, 0, 1, "R4 set line high");
        drain();
        check(line_out, 1'b1, "R1 line high before reset");
        @(negedge clk);
        #7;
        tx_en = 1'b1;
        rst = 1'b1;
        #1;
        check(line_out, 1'b0, "R1 asynchronous clear");
        repeat (2) @(posedge clk);
        #5;
        check(line_out, 1'b0, "R1 held low with enable high");
        @(negedge clk);
        #2;
        tx_en = 1'b0;
        rst = 1'b0;
        model_line = 1'b0;

        send(1, 0, 1, 0, "R3 after reset");
        send(1, 1, 1, 1, "R4 after reset");
        send(0, 0, 0, 0, "R6 after reset");
        drain();

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #4000000;
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: run did not complete, actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule